// File: doc/BRIEF.md
# Stereo Audio Volume and Peak Monitor

This block sits in front of the interpolator of an oversampling sigma-delta DAC and processes a stereo pair of signed 24-bit samples. A sample pair arrives with a one-cycle `in_valid` strobe. Each channel applies its own attenuation and can be muted. The processed pair appears one clock later, together with an `out_valid` pulse.

The attenuation comes in steps of about 0.375 dB. The 8-bit volume code splits into two parts. The low four bits pick one of sixteen fractional multipliers, which together cover one 6 dB span. The high four bits give an arithmetic right shift, one halving per 6 dB. The product is rounded half up and saturated back to 24 bits. Both channels leave reset muted.

Each channel also tracks the largest input magnitude since that register was last read, and a read clears it. Each channel has a zero detector. It is a three-state machine: LIVE (the last sample was nonzero), RUN (counting consecutive zero samples) and FLAGGED (the run reached `ZERO_RUN`). Its transitions are:
- LIVE→RUN on a zero sample.
- RUN→RUN on further zeros.
- RUN→FLAGGED, or LIVE→FLAGGED when `ZERO_RUN` is 1, on the zero sample that completes the run.
- Any state→LIVE on a nonzero sample.
- FLAGGED holds on zeros.

The zero flag output is high only in FLAGGED.

Top module: `audvol_stereo`

## Requirements
- R1: After reset, both mute bits are 1 (address 2 reads 3), both volume codes read 0, both peaks read 0, `out_valid`, both outputs and both zero flags are 0.
- R2: With mute clear, a sample s with volume code c becomes round_half_up(s·G[c mod 16] / 2^(16 + c div 16)), where G[k] = round(65536·10^(−0.375·k/20)). Code 0 passes the sample unchanged.
- R3: A channel whose mute bit is 1 outputs 0 for every sample. Mute bit 0 controls the left channel and bit 1 the right channel. One channel's mute does not affect the other channel.
- R4: Outputs update on the clock edge that captures `in_valid`. `out_valid` is high for exactly that one following cycle. The outputs hold their value between samples.
- R5: A peak register holds the largest input magnitude, measured before volume and mute, of the samples since its last clear. The sample −2^23 counts as 2^23−1.
- R6: Reading a peak (address 3 = left, address 4 = right) returns the held value on `reg_rdata` one cycle later and clears the register. A sample arriving in the same cycle as the read restarts the register at that sample's magnitude.
- R7: A zero flag goes high after `ZERO_RUN` consecutive zero samples on its channel. It drops after the first nonzero sample. The two channels are independent.
- R8: A volume or mute write in the same cycle as `in_valid` affects only later samples. That sample uses the previous setting.
- R9: Addresses 0 and 1 hold the left and right volume codes. Address 2 holds the mute bits in data bits [1:0]. Read data appears on `reg_rdata` the cycle after `reg_rd`. Addresses 5–7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample pair strobe |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| out_valid | output | 1 | Output sample pair strobe |
| out_left | output | 24 | Left processed sample |
| out_right | output | 24 | Right processed sample |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 24 | Registered read data |
| zero_left | output | 1 | Left zero-run flag |
| zero_right | output | 1 | Right zero-run flag |

## Verification
The bench keeps the 24-bit sample and 8-bit volume widths but builds the block with `ZERO_RUN` set to 16 instead of 1024. With that setting, the exact sample on which the flag rises can be reached in a few dozen strobes, and so can the sample that leaves it low. The rise check is placed on both sides of the run threshold. The full-width sample keeps the most negative code and full-scale inputs in reach, for the saturation and magnitude-mapping corners. The full volume range reaches the deepest shift of 31 bits.

// File: rtl/audvol_pkg.sv
package audvol_pkg;

    localparam int FRAC_W     = 16;
    localparam int GAIN_W     = FRAC_W + 1;
    localparam int STEP_SEL_W = 4;
    localparam int STEPS      = 1 << STEP_SEL_W;

    typedef enum logic [1:0] {
        Z_LIVE,
        Z_RUN,
        Z_FLAG
    } zstate_t;

    // Fractional multiplier for fine step k, in units of 2^-FRAC_W.
    function automatic logic [GAIN_W-1:0] step_gain(input int k);
        real v;
        v = (2.0 ** FRAC_W) * (10.0 ** (-0.375 * k / 20.0));
        return GAIN_W'($rtoi(v + 0.5));
    endfunction

endpackage

// File: rtl/audvol_gain.sv
module audvol_gain
    import audvol_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int VOL_W  = 8
) (
    input  logic [DATA_W-1:0] sample_i,
    input  logic [VOL_W-1:0]  vol_i,
    output logic [DATA_W-1:0] sample_o
);

    localparam int COARSE_W = VOL_W - STEP_SEL_W;
    localparam int PROD_W   = DATA_W + GAIN_W + 1;
    localparam int ACC_W    = PROD_W + 1;

    logic [GAIN_W-1:0] gain_tbl [STEPS];

    for (genvar k = 0; k < STEPS; k++) begin : g_tbl
        assign gain_tbl[k] = step_gain(k);
    end

    logic [STEP_SEL_W-1:0]    fine;
    logic [COARSE_W-1:0]      coarse;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  half;
    logic signed [ACC_W-1:0]  shifted;
    int                       sh;

    assign fine   = vol_i[STEP_SEL_W-1:0];
    assign coarse = vol_i[VOL_W-1:STEP_SEL_W];

    always_comb begin
        prod    = $signed(sample_i) * $signed({1'b0, gain_tbl[fine]});
        sh      = FRAC_W + int'(coarse);
        half    = ACC_W'(1) <<< (sh - 1);
        acc     = $signed({prod[PROD_W-1], prod}) + half;
        shifted = acc >>> sh;
        if (shifted[ACC_W-1:DATA_W-1] == '0 || shifted[ACC_W-1:DATA_W-1] == '1) begin
            sample_o = shifted[DATA_W-1:0];
        end else if (shifted[ACC_W-1]) begin
            sample_o = {1'b1, {(DATA_W-1){1'b0}}};
        end else begin
            sample_o = {1'b0, {(DATA_W-1){1'b1}}};
        end
    end

    always_comb begin
        if (vol_i == '0) begin
            AST_UNITY_GAIN: assert (sample_o == sample_i); // R2
        end
    end

endmodule

// File: rtl/audvol_zero.sv
module audvol_zero
    import audvol_pkg::*;
#(
    parameter int ZERO_RUN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic is_zero_i,
    output logic flag_o
);

    localparam int CNT_W = $clog2(ZERO_RUN + 1);

    zstate_t            state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Z_LIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            Z_LIVE, Z_RUN: begin
                if (valid_i) begin
                    if (!is_zero_i) begin
                        state_d = Z_LIVE;
                        cnt_d   = '0;
                    end else if (cnt_q == CNT_W'(ZERO_RUN - 1)) begin
                        state_d = Z_FLAG;
                        cnt_d   = '0;
                    end else begin
                        state_d = Z_RUN;
                        cnt_d   = cnt_q + 1'b1;
                    end
                end
            end
            Z_FLAG: begin
                if (valid_i && !is_zero_i) begin
                    state_d = Z_LIVE;
                end
            end
            default: begin
                state_d = Z_LIVE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        flag_o = (state_q == Z_FLAG);
    end

    AST_ZERO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !is_zero_i) |=> !flag_o); // R7

    AST_ZERO_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(valid_i && is_zero_i)); // R7

endmodule

// File: rtl/audvol_chan.sv
module audvol_chan
    import audvol_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int VOL_W    = 8,
    parameter int ZERO_RUN = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic [VOL_W-1:0]  vol_i,
    input  logic              mute_i,
    input  logic              peak_clr_i,
    output logic [DATA_W-1:0] sample_o,
    output logic [DATA_W-2:0] peak_o,
    output logic              zero_o
);

    localparam int MAG_W = DATA_W - 1;
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] gained;
    logic [DATA_W-1:0] out_q;
    logic [MAG_W-1:0]  mag;
    logic [MAG_W-1:0]  peak_q;
    logic [DATA_W-1:0] neg;

    audvol_gain #(
        .DATA_W (DATA_W),
        .VOL_W  (VOL_W)
    ) u_gain (
        .sample_i (sample_i),
        .vol_i    (vol_i),
        .sample_o (gained)
    );

    audvol_zero #(
        .ZERO_RUN (ZERO_RUN)
    ) u_zero (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid_i),
        .is_zero_i (sample_i == '0),
        .flag_o    (zero_o)
    );

    always_comb begin
        neg = -sample_i;
        if (sample_i == MOST_NEG) begin
            mag = '1;
        end else if (sample_i[DATA_W-1]) begin
            mag = neg[MAG_W-1:0];
        end else begin
            mag = sample_i[MAG_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (valid_i) begin
            out_q <= mute_i ? '0 : gained;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            peak_q <= '0;
        end else if (peak_clr_i) begin
            peak_q <= valid_i ? mag : '0;
        end else if (valid_i && (mag > peak_q)) begin
            peak_q <= mag;
        end
    end

    assign sample_o = out_q;
    assign peak_o   = peak_q;

    AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mute_i) |=> (sample_o == '0)); // R3

    AST_PEAK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !peak_clr_i |=> (peak_o >= $past(peak_o))); // R5

    AST_PEAK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (peak_clr_i && !valid_i) |=> (peak_o == '0)); // R6

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(sample_o)); // R4

endmodule

// File: rtl/audvol_regs.sv
module audvol_regs #(
    parameter int DATA_W = 24,
    parameter int VOL_W  = 8,
    parameter int NCH    = 2,
    parameter int ADDR_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic                          wr_i,
    input  logic [VOL_W-1:0]              wdata_i,
    input  logic                          rd_i,
    input  logic [NCH-1:0][DATA_W-2:0]    peak_i,
    output logic [NCH-1:0][VOL_W-1:0]     vol_o,
    output logic [NCH-1:0]                mute_o,
    output logic [NCH-1:0]                peak_clr_o,
    output logic [DATA_W-1:0]             rdata_o
);

    localparam int MUTE_ADDR = NCH;
    localparam int PEAK_BASE = NCH + 1;
    localparam int LAST_ADDR = PEAK_BASE + NCH - 1;

    logic [NCH-1:0][VOL_W-1:0] vol_q;
    logic [NCH-1:0]            mute_q;
    logic [DATA_W-1:0]         rd_mux;
    logic [DATA_W-1:0]         rdata_q;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vol_q[ch] <= '0;
            end else if (wr_i && addr_i == ADDR_W'(ch)) begin
                vol_q[ch] <= wdata_i;
            end
        end
        assign peak_clr_o[ch] = rd_i && (addr_i == ADDR_W'(PEAK_BASE + ch));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mute_q <= '1;
        end else if (wr_i && addr_i == ADDR_W'(MUTE_ADDR)) begin
            mute_q <= wdata_i[NCH-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (addr_i == ADDR_W'(ch)) begin
                rd_mux = DATA_W'(vol_q[ch]);
            end
            if (addr_i == ADDR_W'(PEAK_BASE + ch)) begin
                rd_mux = DATA_W'(peak_i[ch]);
            end
        end
        if (addr_i == ADDR_W'(MUTE_ADDR)) begin
            rd_mux = DATA_W'(mute_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            rdata_q <= rd_mux;
        end
    end

    assign vol_o   = vol_q;
    assign mute_o  = mute_q;
    assign rdata_o = rdata_q;

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && int'(addr_i) > LAST_ADDR) |=> (rdata_o == '0)); // R9

    AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(peak_clr_o)); // R6

endmodule

// File: rtl/audvol_stereo.sv
module audvol_stereo #(
    parameter int DATA_W   = 24,
    parameter int VOL_W    = 8,
    parameter int ADDR_W   = 3,
    parameter int ZERO_RUN = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [VOL_W-1:0]  reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              zero_left,
    output logic              zero_right
);

    localparam int NCH = 2;

    logic [NCH-1:0][DATA_W-1:0] samp_in;
    logic [NCH-1:0][DATA_W-1:0] samp_out;
    logic [NCH-1:0][DATA_W-2:0] peak;
    logic [NCH-1:0][VOL_W-1:0]  vol;
    logic [NCH-1:0]             mute;
    logic [NCH-1:0]             peak_clr;
    logic [NCH-1:0]             zero;
    logic                       valid_q;

    assign samp_in[0] = in_left;
    assign samp_in[1] = in_right;

    audvol_regs #(
        .DATA_W (DATA_W),
        .VOL_W  (VOL_W),
        .NCH    (NCH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (reg_addr),
        .wr_i       (reg_wr),
        .wdata_i    (reg_wdata),
        .rd_i       (reg_rd),
        .peak_i     (peak),
        .vol_o      (vol),
        .mute_o     (mute),
        .peak_clr_o (peak_clr),
        .rdata_o    (reg_rdata)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        audvol_chan #(
            .DATA_W   (DATA_W),
            .VOL_W    (VOL_W),
            .ZERO_RUN (ZERO_RUN)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .valid_i    (in_valid),
            .sample_i   (samp_in[ch]),
            .vol_i      (vol[ch]),
            .mute_i     (mute[ch]),
            .peak_clr_i (peak_clr[ch]),
            .sample_o   (samp_out[ch]),
            .peak_o     (peak[ch]),
            .zero_o     (zero[ch])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
        end
    end

    assign out_valid  = valid_q;
    assign out_left   = samp_out[0];
    assign out_right  = samp_out[1];
    assign zero_left  = zero[0];
    assign zero_right = zero[1];

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R4

endmodule

// File: tb/audvol_stereo_tb.sv
module audvol_stereo_tb;

    localparam int DW  = 24;
    localparam int ZR  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_left = '0;
    logic [DW-1:0] in_right = '0;
    logic          out_valid;
    logic [DW-1:0] out_left;
    logic [DW-1:0] out_right;
    logic [2:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic          reg_rd = 1'b0;
    logic [DW-1:0] reg_rdata;
    logic          zero_left;
    logic          zero_right;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    audvol_stereo #(.ZERO_RUN(ZR)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .out_valid(out_valid), .out_left(out_left),
        .out_right(out_right), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .zero_left(zero_left), .zero_right(zero_right)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint sgn(input logic [DW-1:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint model(input longint s, input int code);
        longint g, p, r;
        int sh;
        g  = longint'($rtoi(65536.0 * (10.0 ** (-0.375 * (code % 16) / 20.0)) + 0.5));
        sh = 16 + code / 16;
        p  = s * g;
        r  = (p + (longint'(1) <<< (sh - 1))) >>> sh;
        return r;
    endfunction

    task automatic send(input longint l, input longint r);
        @(negedge clk);
        in_valid = 1'b1; in_left = DW'(l); in_right = DW'(r);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output longint v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 3'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        v = longint'(reg_rdata);
    endtask

    task automatic t_reset();
        longint v;
        chk("R1 out_valid", longint'(out_valid), 0);
        chk("R1 out_left", sgn(out_left), 0);
        chk("R1 out_right", sgn(out_right), 0);
        chk("R1 zero_left", longint'(zero_left), 0);
        chk("R1 zero_right", longint'(zero_right), 0);
        rd(0, v); chk("R1 vol left", v, 0);
        rd(1, v); chk("R1 vol right", v, 0);
        rd(2, v); chk("R1 mute", v, 3);
        rd(3, v); chk("R1 peak left", v, 0);
        send(1234, -999);
        chk("R1 muted left", sgn(out_left), 0);
        chk("R1 muted right", sgn(out_right), 0);
    endtask

    task automatic t_gain();
        int codes [8] = '{0, 1, 5, 15, 16, 37, 100, 255};
        longint samps [4] = '{8388607, -8388608, 123457, -3};
        wr(2, 0);
        foreach (codes[i]) begin
            wr(0, codes[i]);
            wr(1, codes[i]);
            foreach (samps[j]) begin
                send(samps[j], samps[(j + 1) % 4]);
                chk("R2 left gain", sgn(out_left), model(samps[j], codes[i]));
                chk("R2 right gain", sgn(out_right), model(samps[(j + 1) % 4], codes[i]));
            end
        end
    endtask

    task automatic t_latency();
        wr(0, 0); wr(1, 0); wr(2, 0);
        @(negedge clk);
        in_valid = 1'b1; in_left = DW'(4444); in_right = DW'(-5555);
        chk("R4 no early update", sgn(out_left) == 4444 ? 1 : 0, 0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R4 out_valid pulse", longint'(out_valid), 1);
        chk("R4 left value", sgn(out_left), 4444);
        @(negedge clk);
        chk("R4 out_valid drops", longint'(out_valid), 0);
        chk("R4 left held", sgn(out_left), 4444);
        chk("R4 right held", sgn(out_right), -5555);
    endtask

    task automatic t_mute();
        wr(0, 0); wr(1, 0);
        wr(2, 1);
        send(7000, -7000);
        chk("R3 left muted", sgn(out_left), 0);
        chk("R3 right open", sgn(out_right), -7000);
        wr(2, 2);
        send(7000, -7000);
        chk("R3 left open", sgn(out_left), 7000);
        chk("R3 right muted", sgn(out_right), 0);
        wr(2, 0);
    endtask

    task automatic t_same_cycle();
        wr(0, 0); wr(2, 0);
        @(negedge clk);
        in_valid = 1'b1; in_left = DW'(100000); in_right = '0;
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'd32;
        @(negedge clk);
        in_valid = 1'b0; reg_wr = 1'b0;
        chk("R8 old volume used", sgn(out_left), 100000);
        send(100000, 0);
        chk("R8 new volume later", sgn(out_left), model(100000, 32));
        @(negedge clk);
        in_valid = 1'b1; in_left = DW'(2000); in_right = DW'(2000);
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 8'd3;
        @(negedge clk);
        in_valid = 1'b0; reg_wr = 1'b0;
        chk("R8 old mute used", sgn(out_right), 2000);
        wr(2, 0);
    endtask

    task automatic t_peak();
        longint v;
        rd(3, v); rd(4, v);
        wr(0, 255); wr(2, 3);
        send(1000, -5000);
        send(-8388608, 20);
        rd(3, v); chk("R5 most negative peak", v, 8388607);
        rd(4, v); chk("R5 right peak pre-gain", v, 5000);
        rd(3, v); chk("R6 cleared by read", v, 0);
        send(700, 1);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 3'd3;
        in_valid = 1'b1; in_left = DW'(-300); in_right = DW'(2);
        @(negedge clk);
        reg_rd = 1'b0; in_valid = 1'b0;
        chk("R6 read returns held", longint'(reg_rdata), 700);
        rd(3, v); chk("R6 restart from new sample", v, 300);
        rd(4, v); chk("R5 right keeps max", v, 2);
        wr(0, 0); wr(2, 0);
    endtask

    task automatic t_zero();
        send(5, 5);
        for (int i = 0; i < ZR - 1; i++) send(0, 9);
        chk("R7 flag low before run", longint'(zero_left), 0);
        send(0, 9);
        chk("R7 flag high at run", longint'(zero_left), 1);
        chk("R7 right independent", longint'(zero_right), 0);
        send(0, 0);
        chk("R7 flag stays", longint'(zero_left), 1);
        send(1, 0);
        chk("R7 flag drops", longint'(zero_left), 0);
    endtask

    task automatic t_map();
        longint v;
        wr(0, 77); wr(1, 150);
        wr(6, 255); wr(5, 255); wr(7, 255);
        rd(0, v); chk("R9 left volume", v, 77);
        rd(1, v); chk("R9 right volume", v, 150);
        rd(2, v); chk("R9 mute unchanged", v, 0);
        rd(5, v); chk("R9 addr5 zero", v, 0);
        rd(6, v); chk("R9 addr6 zero", v, 0);
        rd(7, v); chk("R9 addr7 zero", v, 0);
        send(64, 64);
        chk("R9 writes ignored left", sgn(out_left), model(64, 77));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gain();
        t_latency();
        t_mute();
        t_same_cycle();
        t_peak();
        t_zero();
        t_map();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule